// File: doc/BRIEF.md
# Matrix Key Event Generator with Ghost Rejection

This block sits behind a keyboard matrix scanner. Each scan ends with a snapshot: up to eight (row, column) entries and a count of how many are valid. The block turns successive snapshots into a stream of key events. It emits releases for keys that were held and have now gone, then a raw scan code and a press for every key in the new snapshot. A sync pulse closes each processed snapshot.

Two options shape the result. With ghost rejection enabled, a snapshot of three or more keys that both share a column and share a row is dropped whole. Such a pattern can be an artefact of the matrix wiring. A dropped snapshot produces no events, and the held list stays as it was. With function-layer remapping enabled, one designated scan code acts as a modifier. It produces no events of its own, and every other key in the same snapshot reports a table index moved up by rows×columns into a second code table.

The controller is a five-state machine. IDLE accepts a snapshot (transition *accept*), or drops it (transition *discard*, back to IDLE). RELEASE issues release events; *releases done* leads to SCAN, or to SYNC when the new list is empty. SCAN issues the raw code and leaves on *scan taken* to PRESS. PRESS issues the press, then goes on *next key* back to SCAN or on *last key* to SYNC. SYNC pulses the sync output, stores the new list as the held list, and returns to IDLE (*commit*). From IDLE, *accept* goes straight to SCAN when nothing must be released, and straight to SYNC when there is also nothing to press.

Top module: `key_event_gen`

## Requirements
- R1: After reset, snap_ready is 1, ev_valid and ev_sync are 0, and the held list is empty, so the first snapshot produces no release events.
- R2: The raw scan code of an entry is row×8 + column (row in bits 6:3, column in bits 2:0). ev_kind encodes 0 = release, 1 = raw scan code, 2 = press. A scan-code event carries the 7-bit raw code, zero-extended, on ev_code.
- R3: Release events (kind 0) come first: one for each held table index that is absent from the new snapshot's indices, in held-list order.
- R4: After the releases, each key of the new list, in list order, yields a scan-code event followed at once by a press event (kind 2) whose code is the key's table index. Without a function key, the table index equals the raw code.
- R5: When fn_en is 1 and an entry's raw code equals fn_code, that entry yields no event, and every other key's press index is its raw code + 128. Its scan-code event still carries the raw code. With fn_en at 0, that code is an ordinary key.
- R6: When ghost_en is 1 and at least 3 keys remain after function-key removal, the snapshot is discarded if some key shares a column with a later key and some key shares a row with a later key. It then yields no events and no sync, the held list is unchanged, and snap_ready is 1 again one cycle after acceptance.
- R7: The same pattern is processed normally when ghost_en is 0. A snapshot that shares rows but no columns is processed normally when ghost_en is 1.
- R8: A snapshot with count 0 releases every held key, issues sync, and leaves the held list empty.
- R9: Each processed snapshot ends with exactly one single-cycle ev_sync pulse, after its last event, with ev_valid low in that cycle.
- R10: While ev_valid is 1 and ev_ready is 0, ev_valid, ev_kind and ev_code hold their values.
- R11: snap_ready is 0 from the cycle after a processed snapshot is accepted through the sync cycle, and returns to 1 in the cycle after sync.
- R12: Entries at positions at or above snap_cnt have no effect, and a count above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Snapshot can be taken this cycle |
| snap_cnt | input | 4 | Number of valid entries |
| snap_row | input | 32 | Entry rows, 4 bits per entry, entry 0 in the low bits |
| snap_col | input | 24 | Entry columns, 3 bits per entry, entry 0 in the low bits |
| ghost_en | input | 1 | Enable ghost rejection |
| fn_en | input | 1 | Enable function-layer remapping |
| fn_code | input | 7 | Raw scan code of the function key |
| ev_valid | output | 1 | Event presented |
| ev_ready | input | 1 | Event taken when high with ev_valid |
| ev_kind | output | 2 | 0 release, 1 raw scan code, 2 press |
| ev_code | output | 8 | Table index or raw scan code |
| ev_sync | output | 1 | One-cycle pulse after the last event of a snapshot |

## Verification
The evaluation is done entirely in the acceptance cycle, so the first event of a snapshot is presented in the cycle after the accepting edge. Each later event appears in the cycle after the handshake of the one before it. The sync pulse occupies the cycle after the final handshake, and snap_ready is high again one cycle later. A discarded snapshot leaves snap_ready high already in the cycle after acceptance. The bench samples every output at the falling edge, between the edges that move them, and compares events in order against a queue filled from the requirements. Because ev_ready is throttled by a pseudo-random pattern, no check depends on absolute cycle counts except the one-cycle snap_ready and discard checks.

// File: rtl/kev_pkg.sv
package kev_pkg;

    typedef enum logic [1:0] {
        EVK_RELEASE = 2'd0,
        EVK_SCAN    = 2'd1,
        EVK_PRESS   = 2'd2
    } evkind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_SCAN,
        ST_PRESS,
        ST_SYNC
    } state_e;

endpackage

// File: rtl/kev_compact.sv
// Packs the valid snapshot entries into raw scan codes, removing the function key.
module kev_compact #(
    parameter int SLOTS = 8,
    parameter int ROW_W = 4,
    parameter int COL_W = 3,
    localparam int SCAN_W = ROW_W + COL_W,
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [CNT_W-1:0]              cnt_i,
    input  logic [SLOTS*ROW_W-1:0]        row_i,
    input  logic [SLOTS*COL_W-1:0]        col_i,
    input  logic                          fn_en_i,
    input  logic [SCAN_W-1:0]             fn_code_i,
    output logic [SLOTS-1:0][SCAN_W-1:0]  list_o,
    output logic [CNT_W-1:0]              cnt_o,
    output logic                          fn_seen_o
);

    logic [CNT_W-1:0]  lim;
    logic [SCAN_W-1:0] code;

    always_comb begin
        lim       = (cnt_i > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : cnt_i;
        list_o    = '0;
        cnt_o     = '0;
        fn_seen_o = 1'b0;
        code      = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (CNT_W'(i) < lim) begin
                code = {row_i[i*ROW_W +: ROW_W], col_i[i*COL_W +: COL_W]};
                if (fn_en_i && (code == fn_code_i)) begin
                    fn_seen_o = 1'b1;
                end else begin
                    list_o[cnt_o[IDX_W-1:0]] = code;
                    cnt_o = cnt_o + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/kev_ghost.sv
// Flags a list where one pair of keys shares a column and some pair shares a row.
module kev_ghost #(
    parameter int SLOTS  = 8,
    parameter int SCAN_W = 7,
    parameter int COL_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic                          en_i,
    input  logic [SLOTS-1:0][SCAN_W-1:0]  list_i,
    input  logic [CNT_W-1:0]              cnt_i,
    output logic                          ghost_o
);

    logic same_row;
    logic same_col;

    always_comb begin
        same_row = 1'b0;
        same_col = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            for (int j = i + 1; j < SLOTS; j++) begin
                if (CNT_W'(j) < cnt_i) begin
                    if (list_i[i][COL_W-1:0] == list_i[j][COL_W-1:0])
                        same_col = 1'b1;
                    if (list_i[i][SCAN_W-1:COL_W] == list_i[j][SCAN_W-1:COL_W])
                        same_row = 1'b1;
                end
            end
        end
        ghost_o = en_i && (cnt_i >= CNT_W'(3)) && same_col && same_row;
    end

endmodule

// File: rtl/kev_diff.sv
// Marks each held index that does not appear in the new list.
module kev_diff #(
    parameter int SLOTS  = 8,
    parameter int CODE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [SLOTS-1:0][CODE_W-1:0]  held_i,
    input  logic [CNT_W-1:0]              held_cnt_i,
    input  logic [SLOTS-1:0][CODE_W-1:0]  new_i,
    input  logic [CNT_W-1:0]              new_cnt_i,
    output logic [SLOTS-1:0]              gone_o
);

    for (genvar h = 0; h < SLOTS; h++) begin : g_held
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int n = 0; n < SLOTS; n++) begin
                if ((CNT_W'(n) < new_cnt_i) && (new_i[n] == held_i[h]))
                    hit = 1'b1;
            end
        end
        assign gone_o[h] = (CNT_W'(h) < held_cnt_i) && !hit;
    end

endmodule

// File: rtl/key_event_gen.sv
module key_event_gen
    import kev_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int COLS  = 8,
    parameter int SLOTS = 8,
    localparam int ROW_W     = $clog2(ROWS),
    localparam int COL_W     = $clog2(COLS),
    localparam int SCAN_W    = ROW_W + COL_W,
    localparam int CODE_W    = SCAN_W + 1,
    localparam int CNT_W     = $clog2(SLOTS + 1),
    localparam int IDX_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int FN_OFFSET = ROWS * COLS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snap_valid,
    output logic                    snap_ready,
    input  logic [CNT_W-1:0]        snap_cnt,
    input  logic [SLOTS*ROW_W-1:0]  snap_row,
    input  logic [SLOTS*COL_W-1:0]  snap_col,
    input  logic                    ghost_en,
    input  logic                    fn_en,
    input  logic [SCAN_W-1:0]       fn_code,
    output logic                    ev_valid,
    input  logic                    ev_ready,
    output logic [1:0]              ev_kind,
    output logic [CODE_W-1:0]       ev_code,
    output logic                    ev_sync
);

    // Combinational evaluation of the offered snapshot
    logic [SLOTS-1:0][SCAN_W-1:0] c_list;
    logic [CNT_W-1:0]             c_cnt;
    logic                         c_fn;
    logic [CODE_W-1:0]            c_add;
    logic [SLOTS-1:0][CODE_W-1:0] c_code;
    logic                         c_ghost;
    logic [SLOTS-1:0]             c_gone;

    // Registered state
    state_e                       state_q, state_d;
    logic [SLOTS-1:0][SCAN_W-1:0] new_list_q;
    logic                         new_fn_q;
    logic [CNT_W-1:0]             new_cnt_q;
    logic [SLOTS-1:0]             gone_q;
    logic [CNT_W-1:0]             idx_q;
    logic [SLOTS-1:0][CODE_W-1:0] held_q;
    logic [CNT_W-1:0]             held_cnt_q;

    logic [CODE_W-1:0]            q_add;
    logic [SLOTS-1:0][CODE_W-1:0] new_code;
    logic [IDX_W-1:0]             rel_idx;
    logic [SLOTS-1:0]             rel_onehot;
    logic [IDX_W-1:0]             key_idx;
    logic                         take;
    logic                         hs;
    logic                         last_key;
    evkind_e                      kind_c;

    kev_compact #(
        .SLOTS (SLOTS),
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_compact (
        .cnt_i     (snap_cnt),
        .row_i     (snap_row),
        .col_i     (snap_col),
        .fn_en_i   (fn_en),
        .fn_code_i (fn_code),
        .list_o    (c_list),
        .cnt_o     (c_cnt),
        .fn_seen_o (c_fn)
    );

    kev_ghost #(
        .SLOTS  (SLOTS),
        .SCAN_W (SCAN_W),
        .COL_W  (COL_W),
        .CNT_W  (CNT_W)
    ) u_ghost (
        .en_i    (ghost_en),
        .list_i  (c_list),
        .cnt_i   (c_cnt),
        .ghost_o (c_ghost)
    );

    assign c_add = c_fn     ? CODE_W'(FN_OFFSET) : '0;
    assign q_add = new_fn_q ? CODE_W'(FN_OFFSET) : '0;

    for (genvar k = 0; k < SLOTS; k++) begin : g_code
        assign c_code[k]   = {1'b0, c_list[k]} + c_add;
        assign new_code[k] = {1'b0, new_list_q[k]} + q_add;
    end

    kev_diff #(
        .SLOTS  (SLOTS),
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_diff (
        .held_i     (held_q),
        .held_cnt_i (held_cnt_q),
        .new_i      (c_code),
        .new_cnt_i  (c_cnt),
        .gone_o     (c_gone)
    );

    // Lowest pending release
    always_comb begin
        rel_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (gone_q[i]) rel_idx = IDX_W'(i);
        end
    end
    assign rel_onehot = SLOTS'(1) << rel_idx;

    assign key_idx  = idx_q[IDX_W-1:0];
    assign take     = (state_q == ST_IDLE) && snap_valid && !c_ghost;
    assign hs       = ev_valid && ev_ready;
    assign last_key = (idx_q + CNT_W'(1)) == new_cnt_q;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (c_gone != '0)        state_d = ST_RELEASE;
                    else if (c_cnt != '0)    state_d = ST_SCAN;
                    else                     state_d = ST_SYNC;
                end
            end
            ST_RELEASE: begin
                if (hs && ((gone_q & ~rel_onehot) == '0))
                    state_d = (new_cnt_q != '0) ? ST_SCAN : ST_SYNC;
            end
            ST_SCAN: begin
                if (hs) state_d = ST_PRESS;
            end
            ST_PRESS: begin
                if (hs) state_d = last_key ? ST_SYNC : ST_SCAN;
            end
            ST_SYNC: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Snapshot and held-list registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_list_q <= '0;
            new_fn_q   <= 1'b0;
            new_cnt_q  <= '0;
            gone_q     <= '0;
            idx_q      <= '0;
            held_q     <= '0;
            held_cnt_q <= '0;
        end else begin
            if (take) begin
                new_list_q <= c_list;
                new_fn_q   <= c_fn;
                new_cnt_q  <= c_cnt;
                gone_q     <= c_gone;
                idx_q      <= '0;
            end
            if ((state_q == ST_RELEASE) && hs)
                gone_q <= gone_q & ~rel_onehot;
            if ((state_q == ST_PRESS) && hs)
                idx_q <= idx_q + CNT_W'(1);
            if (state_q == ST_SYNC) begin
                held_q     <= new_code;
                held_cnt_q <= new_cnt_q;
            end
        end
    end

    // Outputs
    always_comb begin
        snap_ready = 1'b0;
        ev_valid   = 1'b0;
        kind_c     = EVK_RELEASE;
        ev_code    = '0;
        ev_sync    = 1'b0;
        unique case (state_q)
            ST_IDLE: snap_ready = 1'b1;
            ST_RELEASE: begin
                ev_valid = 1'b1;
                kind_c   = EVK_RELEASE;
                ev_code  = held_q[rel_idx];
            end
            ST_SCAN: begin
                ev_valid = 1'b1;
                kind_c   = EVK_SCAN;
                ev_code  = {1'b0, new_list_q[key_idx]};
            end
            ST_PRESS: begin
                ev_valid = 1'b1;
                kind_c   = EVK_PRESS;
                ev_code  = new_code[key_idx];
            end
            ST_SYNC: ev_sync = 1'b1;
            default: ev_sync = 1'b0;
        endcase
    end

    assign ev_kind = kind_c;

endmodule

// File: rtl/key_event_gen_chk.sv
module key_event_gen_chk
    import kev_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int SCAN_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snap_ready,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [1:0]        ev_kind,
    input logic [CODE_W-1:0] ev_code,
    input logic              ev_sync
);

    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_kind) && $stable(ev_code)));

    a_r9_sync_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sync |-> !ev_valid);

    a_r9_sync_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sync |=> !ev_sync);

    a_r11_busy_while_emitting: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid || ev_sync) |-> !snap_ready);

    a_r11_ready_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sync |=> snap_ready);

    a_r4_press_follows_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_kind == EVK_SCAN) |=> (ev_valid && ev_kind == EVK_PRESS));

    a_r3_no_release_after_press: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && ev_kind == EVK_PRESS) |=> !(ev_valid && ev_kind == EVK_RELEASE));

    a_r2_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_kind != 2'd3));

    a_r2_scan_code_width: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == EVK_SCAN) |-> ((ev_code >> SCAN_W) == '0));

endmodule

bind key_event_gen key_event_gen_chk #(
    .CODE_W (CODE_W),
    .SCAN_W (SCAN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .snap_ready (snap_ready),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_kind    (ev_kind),
    .ev_code    (ev_code),
    .ev_sync    (ev_sync)
);

// File: tb/sim_key_event_gen.sv
module sim_key_event_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snap_valid = 1'b0;
    logic        snap_ready;
    logic [3:0]  snap_cnt = '0;
    logic [31:0] snap_row = '0;
    logic [23:0] snap_col = '0;
    logic        ghost_en = 1'b0;
    logic        fn_en = 1'b0;
    logic [6:0]  fn_code = '0;
    logic        ev_valid;
    logic        ev_ready = 1'b0;
    logic [1:0]  ev_kind;
    logic [7:0]  ev_code;
    logic        ev_sync;

    always #5 clk = ~clk;

    key_event_gen u0 (
        .clk (clk), .rst_n (rst_n),
        .snap_valid (snap_valid), .snap_ready (snap_ready),
        .snap_cnt (snap_cnt), .snap_row (snap_row), .snap_col (snap_col),
        .ghost_en (ghost_en), .fn_en (fn_en), .fn_code (fn_code),
        .ev_valid (ev_valid), .ev_ready (ev_ready),
        .ev_kind (ev_kind), .ev_code (ev_code), .ev_sync (ev_sync)
    );

    int checks = 0;
    int fails = 0;
    int events_seen = 0;
    bit done = 1'b0;

    logic [9:0] exp_q[$];      // {kind, code}; kind 3 marks the sync pulse
    string      tag_q[$];

    int st_row[8];
    int st_col[8];
    int held[8];
    int held_cnt = 0;

    // ev_ready throttle
    logic [7:0] lfsr = 8'hA5;
    bit         hold_off = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ev_ready = !hold_off && (lfsr[0] || lfsr[2]);
        end
    end

    // Monitor / scoreboard
    bit         stall_seen = 1'b0;
    logic [1:0] stall_kind;
    logic [7:0] stall_code;

    task automatic take_item(input logic [9:0] got);
        logic [9:0] want;
        string      t;
        events_seen++;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R6: unexpected output kind=%0d code=%0d, expected nothing",
                     got[9:8], got[7:0]);
        end else begin
            want = exp_q.pop_front();
            t    = tag_q.pop_front();
            if (got !== want) begin
                fails++;
                $display("FAIL %s: kind=%0d code=%0d, expected kind=%0d code=%0d",
                         t, got[9:8], got[7:0], want[9:8], want[7:0]);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_seen) begin
                checks++;
                if (!(ev_valid && ev_kind == stall_kind && ev_code == stall_code)) begin
                    fails++;
                    $display("FAIL R10: valid=%0b kind=%0d code=%0d, expected held kind=%0d code=%0d",
                             ev_valid, ev_kind, ev_code, stall_kind, stall_code);
                end
            end
            stall_seen = ev_valid && !ev_ready;
            stall_kind = ev_kind;
            stall_code = ev_code;
            if (ev_valid && ev_ready) take_item({ev_kind, ev_code});
            if (ev_sync) take_item({2'd3, 8'd0});
        end
    end

    task automatic clear_keys();
        for (int i = 0; i < 8; i++) begin
            st_row[i] = 0;
            st_col[i] = 0;
        end
    endtask

    task automatic put(input int i, input int r, input int c);
        st_row[i] = r;
        st_col[i] = c;
    endtask

    task automatic push(input int kind, input int code, input string t);
        exp_q.push_back({2'(kind), 8'(code)});
        tag_q.push_back(t);
    endtask

    // Builds the expected stream from the requirements and offers the snapshot
    task automatic send(input int cnt, input bit g, input bit f, input int fc, input string t);
        int  lim, n, seen0;
        int  sc[8];
        int  code[8];
        bit  fs, sr, scl, gh, found;
        lim = (cnt > 8) ? 8 : cnt;
        n   = 0;
        fs  = 1'b0;
        for (int i = 0; i < lim; i++) begin
            int s;
            s = st_row[i] * 8 + st_col[i];
            if (f && s == fc) fs = 1'b1;
            else begin
                sc[n] = s;
                n++;
            end
        end
        sr = 1'b0;
        scl = 1'b0;
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++) begin
                if (sc[i] % 8 == sc[j] % 8) scl = 1'b1;
                if (sc[i] / 8 == sc[j] / 8) sr = 1'b1;
            end
        gh = g && (n >= 3) && sr && scl;
        if (!gh) begin
            for (int i = 0; i < n; i++) code[i] = sc[i] + (fs ? 128 : 0);
            for (int h = 0; h < held_cnt; h++) begin
                found = 1'b0;
                for (int i = 0; i < n; i++) if (code[i] == held[h]) found = 1'b1;
                if (!found) push(0, held[h], {"R3 release (", t, ")"});
            end
            for (int i = 0; i < n; i++) begin
                push(1, sc[i], {"R2 scan code (", t, ")"});
                push(2, code[i], fs ? {"R5 press (", t, ")"} : {"R4 press (", t, ")"});
            end
            push(3, 0, {"R9 sync (", t, ")"});
            for (int i = 0; i < n; i++) held[i] = code[i];
            held_cnt = n;
        end

        for (int i = 0; i < 8; i++) begin
            snap_row[i*4 +: 4] = 4'(st_row[i]);
            snap_col[i*3 +: 3] = 3'(st_col[i]);
        end
        snap_cnt   = 4'(cnt);
        ghost_en   = g;
        fn_en      = f;
        fn_code    = 7'(fc);
        snap_valid = 1'b1;
        seen0      = events_seen;
        while (!snap_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        snap_valid = 1'b0;
        if (gh) begin
            checks++;
            if (!snap_ready) begin
                fails++;
                $display("FAIL R6: snap_ready=%0b after discard, expected 1 (%s)", snap_ready, t);
            end
            repeat (3) @(negedge clk);
            checks++;
            if (events_seen != seen0) begin
                fails++;
                $display("FAIL R6: %0d outputs after discarded snapshot, expected 0 (%s)",
                         events_seen - seen0, t);
            end
        end else begin
            checks++;
            if (snap_ready) begin
                fails++;
                $display("FAIL R11: snap_ready=%0b after acceptance, expected 0 (%s)", snap_ready, t);
            end
            while (exp_q.size() != 0 || !snap_ready) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (!(snap_ready === 1'b1 && ev_valid === 1'b0 && ev_sync === 1'b0)) begin
            fails++;
            $display("FAIL R1: ready=%0b valid=%0b sync=%0b, expected 1 0 0",
                     snap_ready, ev_valid, ev_sync);
        end

        // R1/R2: first snapshot, no releases
        clear_keys(); put(0, 1, 2); put(1, 3, 4);
        send(2, 1'b0, 1'b0, 0, "R1");
        // R3: partial change
        clear_keys(); put(0, 3, 4); put(1, 5, 0);
        send(2, 1'b0, 1'b0, 0, "R3");
        // R6: ghost pattern discarded
        clear_keys(); put(0, 0, 0); put(1, 0, 1); put(2, 1, 0);
        send(3, 1'b1, 1'b0, 0, "R6");
        // R7: same pattern with filter off
        send(3, 1'b0, 1'b0, 0, "R7");
        // R7: shared rows only, filter on
        clear_keys(); put(0, 2, 1); put(1, 2, 2); put(2, 3, 3);
        send(3, 1'b1, 1'b0, 0, "R7");
        // R5: function key removes itself, defusing a ghost pattern
        clear_keys(); put(0, 7, 7); put(1, 7, 1); put(2, 1, 7);
        send(3, 1'b1, 1'b1, 63, "R5");
        // R5: fn code with remapping off is an ordinary key
        clear_keys(); put(0, 7, 7);
        send(1, 1'b0, 1'b0, 63, "R5");
        // R10: long stall at the start of an event burst
        hold_off = 1'b1;
        clear_keys(); put(0, 6, 6); put(1, 2, 5);
        fork
            begin repeat (6) @(negedge clk); hold_off = 1'b0; end
            send(2, 1'b0, 1'b0, 0, "R10");
        join
        // R12: entries beyond count ignored
        clear_keys(); put(0, 0, 5); put(1, 4, 4); put(2, 6, 6); put(3, 2, 5);
        send(2, 1'b0, 1'b0, 0, "R12");
        // R12: count above slot number clamps to 8
        clear_keys();
        for (int i = 0; i < 8; i++) put(i, i, i);
        send(12, 1'b0, 1'b0, 0, "R12");
        // R8: empty snapshot releases everything
        clear_keys();
        send(0, 1'b0, 1'b0, 0, "R8");
        // R8: empty snapshot with nothing held gives only sync
        send(0, 1'b1, 1'b1, 0, "R8");
        // R4: three keys after empty, row-only sharing, fn enabled but absent
        clear_keys(); put(0, 15, 7); put(1, 15, 0); put(2, 9, 3);
        send(3, 1'b1, 1'b1, 5, "R4");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d expected outputs never produced, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule